// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two 32-bit operands over a fixed number of clock cycles and returns a 64-bit product as an upper word and a lower word. It uses one shift register for both the multiplier and the growing product. The multiplier sits in the lower half of that register, and one guard bit sits below its least significant bit. Each cycle, the two lowest bits of the register choose whether the multiplicand is added to the upper half, subtracted from it, or left alone. The whole register then shifts right by one place. After one iteration per operand bit, the register holds the finished product.

A mode input chooses the interpretation. In two's-complement mode the block uses Booth bit-pair recoding with an arithmetic shift. In unsigned mode it uses plain shift-and-add, and the adder's carry becomes the new top bit. A client pulses `start` with the operands while the block is idle. It then waits for the one-cycle `done` pulse and reads the two words together with a flag. The flag reports whether the product fits in the lower word alone.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `busy`, `done`, `ovf`, `prod_hi` and `prod_lo` are all 0.
- R2: A `start` sampled high while idle raises `busy` in the next cycle. `done` is high for exactly one cycle, with `busy` low, in the (W+1)-th cycle after the accepting clock edge (33 cycles for W = 32).
- R3: With `signed_mode` = 1, `{prod_hi, prod_lo}` at `done` equals the 64-bit two's-complement product of `mcand` and `mplier`. Operand bit 31 is the sign, and the product is also correct when both operands are the most negative value.
- R4: With `signed_mode` = 0, `{prod_hi, prod_lo}` at `done` equals the 64-bit unsigned product of `mcand` and `mplier`.
- R5: While `busy` is high, `start` and any change on `mcand`, `mplier` or `signed_mode` have no effect on the product delivered at `done`.
- R6: For a product computed with `signed_mode` = 0, `ovf` is 1 exactly when `prod_hi` is not all zeros.
- R7: For a product computed with `signed_mode` = 1, `ovf` is 1 exactly when `prod_hi` differs from bit 31 of `prod_lo` copied into all 32 bits.
- R8: After `done`, `prod_hi`, `prod_lo` and `ovf` hold their values until the next accepted `start`, whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a multiplication when the block is idle |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | 32 | Multiplicand |
| mplier | input | 32 | Multiplier |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| prod_hi | output | 32 | Upper word of the product |
| prod_lo | output | 32 | Lower word of the product |
| ovf | output | 1 | Product does not fit in the lower word for the mode used |

## Verification
The assertions check the handshake on every cycle. They cover the exact iteration count from an accepted start to `done`, the single-cycle `done` pulse with `busy` low, the stability of the result while idle, and the fact that the captured operands stay frozen while busy. They also check the overflow flag against the words it describes. Only the bench's scenarios can show that the product arithmetic is right. Those scenarios include the Booth recoding on random and extreme signed operands, the carry path in unsigned mode, and the result after a start request made in the middle of a run.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    // Action chosen for one iteration on the upper half of the register.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } step_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Signed: Booth pair {bit0, guard}. Unsigned: add when bit0 is set.
    function automatic step_op_e pick_op(input logic is_signed,
                                         input logic bit0,
                                         input logic guard);
        step_op_e op;
        if (!is_signed) begin
            op = bit0 ? OP_ADD : OP_NONE;
        end else begin
            case ({bit0, guard})
                2'b10:   op = OP_SUB;
                2'b01:   op = OP_ADD;
                default: op = OP_NONE;
            endcase
        end
        return op;
    endfunction

endpackage

// File: rtl/bsm_ctrl.sv
module bsm_ctrl #(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load
);
    import booth_mul_pkg::*;

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    run_state_e    state_q;
    logic [CW-1:0] iter_q;

    assign busy = (state_q == ST_RUN);
    assign load = start && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        iter_q  <= '0;
                    end
                end
                ST_RUN: begin
                    if (iter_q == LAST) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bsm_addsub.sv
module bsm_addsub #(
    parameter int W = 32
) (
    input  logic                     is_signed,
    input  booth_mul_pkg::step_op_e  op,
    input  logic [W-1:0]             acc,
    input  logic [W-1:0]             addend,
    output logic [W:0]               result
);
    import booth_mul_pkg::*;

    logic [W:0] acc_x;
    logic [W:0] add_x;

    // One extension bit: sign in signed mode, zero (carry slot) otherwise.
    assign acc_x = {is_signed & acc[W-1], acc};
    assign add_x = {is_signed & addend[W-1], addend};

    always_comb begin
        case (op)
            OP_ADD:  result = acc_x + add_x;
            OP_SUB:  result = acc_x - add_x;
            default: result = acc_x;
        endcase
    end

endmodule

// File: rtl/bsm_ovf.sv
module bsm_ovf #(
    parameter int W = 32
) (
    input  logic         is_signed,
    input  logic [W-1:0] hi_word,
    input  logic [W-1:0] lo_word,
    output logic         ovf
);
    logic [W-1:0] fill;

    assign fill = is_signed ? {W{lo_word[W-1]}} : '0;
    assign ovf  = (hi_word != fill);

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] mcand,
    input  logic [W-1:0] mplier,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod_hi,
    output logic [W-1:0] prod_lo,
    output logic         ovf
);
    import booth_mul_pkg::*;

    logic         load;
    logic [W-1:0] upper_q;
    logic [W-1:0] lower_q;
    logic         guard_q;
    logic [W-1:0] mcand_q;
    logic         mode_q;
    step_op_e     op;
    logic [W:0]   sum;

    bsm_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load)
    );

    assign op = pick_op(mode_q, lower_q[0], guard_q);

    bsm_addsub #(.W(W)) u_addsub (
        .is_signed (mode_q),
        .op        (op),
        .acc       (upper_q),
        .addend    (mcand_q),
        .result    (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            lower_q <= '0;
            guard_q <= 1'b0;
            mcand_q <= '0;
            mode_q  <= 1'b0;
        end else if (load) begin
            upper_q <= '0;
            lower_q <= mplier;
            guard_q <= 1'b0;
            mcand_q <= mcand;
            mode_q  <= signed_mode;
        end else if (busy) begin
            // Shift right by one: top bit is sign or carry from the extended sum.
            upper_q <= sum[W:1];
            lower_q <= {sum[0], lower_q[W-1:1]};
            guard_q <= lower_q[0];
        end
    end

    assign prod_hi = upper_q;
    assign prod_lo = lower_q;

    bsm_ovf #(.W(W)) u_ovf (
        .is_signed (mode_q),
        .hi_word   (upper_q),
        .lo_word   (lower_q),
        .ovf       (ovf)
    );

endmodule

// File: rtl/bsm_checker.sv
module bsm_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] prod_hi,
    input logic [W-1:0] prod_lo,
    input logic         ovf,
    input logic         mode_q,
    input logic [W-1:0] mcand_q
);
    localparam int NW = $clog2(W + 1) + 1;
    localparam logic [NW-1:0] W_CNT = NW'(W);

    logic [NW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)                run_cnt <= '0;
        else if (start && !busy) run_cnt <= '0;
        else if (busy)           run_cnt <= run_cnt + 1'b1;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == W_CNT) && !busy);

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(mcand_q) && $stable(mode_q));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(prod_hi) && $stable(prod_lo) && $stable(ovf));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q && prod_hi == '0) |-> !ovf);

    p_sign_fill_r7: assert property (@(posedge clk) disable iff (rst)
        (done && mode_q && prod_hi == {W{prod_lo[W-1]}}) |-> !ovf);

endmodule

bind booth_seq_mul bsm_checker #(.W(W)) u_bsm_checker (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .prod_hi (prod_hi),
    .prod_lo (prod_lo),
    .ovf     (ovf),
    .mode_q  (mode_q),
    .mcand_q (mcand_q)
);

// File: tb/tb_booth_seq_mul.sv
module tb_booth_seq_mul;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [W-1:0] mplier = '0;
    logic         busy, done, ovf;
    logic [W-1:0] prod_hi, prod_lo;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    booth_seq_mul #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .mcand(mcand), .mplier(mplier), .busy(busy), .done(done),
        .prod_hi(prod_hi), .prod_lo(prod_lo), .ovf(ovf)
    );

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a,
                                                input logic [W-1:0] b,
                                                input logic s);
        logic [2*W-1:0] ax, bx;
        ax = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        bx = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ax * bx;
    endfunction

    function automatic logic ref_ovf(input logic [2*W-1:0] p, input logic s);
        if (s) return p[2*W-1:W] != {W{p[W-1]}};
        return p[2*W-1:W] != '0;
    endfunction

    task automatic chk(input string tag, input logic [2*W-1:0] act,
                       input logic [2*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input bit poke, input string tag);
        logic [2*W-1:0] exp;
        logic [2*W-1:0] held;
        int n;
        exp = ref_prod(a, b, s);
        @(negedge clk);
        mcand = a; mplier = b; signed_mode = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk("R2 busy after start", 64'(busy), 64'(1));
        if (poke) begin
            // R5: new request and new operands during the run
            mcand = ~a; mplier = b ^ 32'h5A5A_A5A5; signed_mode = ~s; start = 1'b1;
            @(negedge clk);
            start = 1'b0; n++;
        end
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R2 done latency", 64'(n), 64'(W + 1));
        chk("R2 busy low at done", 64'(busy), 64'(0));
        chk({tag, " product"}, {prod_hi, prod_lo}, exp);
        chk(s ? "R7 signed ovf" : "R6 unsigned ovf", 64'(ovf), 64'(ref_ovf(exp, s)));
        held = {prod_hi, prod_lo};
        @(negedge clk);
        chk("R2 done single cycle", 64'(done), 64'(0));
        chk("R8 result held", {prod_hi, prod_lo}, held);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [2*W-1:0] held;
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {prod_hi, prod_lo}, '0);
        chk("R1 reset flags", 64'({busy, done, ovf}), 64'(0));
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", 64'({busy, done, ovf, |prod_hi, |prod_lo}), 64'(0));

        // Directed corners
        run(32'd2, 32'hFFFF_FFFD, 1'b1, 0, "R3 2x-3");
        run(32'h8000_0000, 32'h8000_0000, 1'b1, 0, "R3 minneg squared");
        run(32'h8000_0000, 32'd1, 1'b1, 0, "R3 minneg x1");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 0, "R3 -1x-1");
        run(32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 0, "R3 max x minneg");
        run(32'h0, 32'h1234_5678, 1'b1, 0, "R3 zero");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 0, "R4 max squared");
        run(32'h0001_0000, 32'h0001_0000, 1'b0, 0, "R4 carry into hi");
        run(32'h8000_0000, 32'd2, 1'b0, 0, "R4 top bit");
        run(32'd12345, 32'd6789, 1'b0, 0, "R4 small");
        run(32'hDEAD_BEEF, 32'h1357_9BDF, 1'b1, 1, "R5 ignored start signed");
        run(32'h0BAD_F00D, 32'hCAFE_0001, 1'b0, 1, "R5 ignored start unsigned");

        // R8: inputs wiggle while idle, no start
        held = {prod_hi, prod_lo};
        for (int i = 0; i < 5; i++) begin
            mcand = $urandom; mplier = $urandom; signed_mode = ~signed_mode;
            @(negedge clk);
        end
        chk("R8 idle hold", {prod_hi, prod_lo}, held);

        for (int i = 0; i < 40; i++) begin
            run($urandom, $urandom, 1'b1, (i % 7) == 3, "R3 random signed");
            run($urandom, $urandom, 1'b0, (i % 9) == 4, "R4 random unsigned");
        end
        for (int i = 0; i < 10; i++) begin
            run($urandom & 32'h0000_FFFF, $urandom & 32'h0000_7FFF, 1'b0, 0, "R6 no-overflow unsigned");
            run(32'(-($urandom % 1000)), $urandom % 1000, 1'b1, 0, "R7 no-overflow signed");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule